// File: doc/BRIEF.md
# Combined Register-Read Sequencer

This block sits in front of the byte engine of a two-wire bus master. It turns one go strobe into the whole address prologue of a transfer. There is no step-by-step software involvement. It captures a slave-address word, a register-address word with a valid flag per byte, a mode and a receive length. It then issues byte-level commands (START, repeated START, write byte, STOP) one at a time to the engine. Each command completes when the engine returns a done strobe that carries the sampled acknowledge.

Four modes are supported:

- **Write-only.** START, the slave address with the direction bit cleared, the valid register bytes, and then a hand-off to the transmit burst path.
- **Plain read.** START, the slave address with the direction bit set, and then a hand-off to the receive burst path.
- **Write-then-read.** Writes the register bytes, then issues a repeated START and the read address.
- **Read-then-read.** Like write-then-read, except that the first address already carries the direction bit set.

A missing acknowledge on any address or register byte aborts the transfer with a STOP.

Top module: `i2c_regread_seq`

## Requirements
- R1: After reset the block is idle: busy_o, cmd_valid_o, tx_go_o, rx_go_o and nak_evt_o are all 0.
- R2: A go_i pulse while idle is ignored when bit 24 (slave-address valid) of slv_reg_i is 0: no command is issued and busy_o stays 0.
- R3: An accepted go begins with a START command, which is followed by a write of the slave byte. Command codes on cmd_op_o are START=0, repeated START=1, WRITE=2 and STOP=3. Mode codes are write-only=0, plain read=1, write-then-read=2 and read-then-read=3. The slave byte is slv_reg_i[7:1] with bit 0 forced as follows: 0 in write-only mode, 0 in write-then-read mode with at least one register flag set, and 1 otherwise.
- R4: In modes 0, 2 and 3, register bytes are written after the slave byte, lowest byte first. Only bytes whose flag is set are written. The bytes are reg_addr_i[7:0], [15:8] and [23:16], and their flags are bits 24, 25 and 26 respectively.
- R5: In modes 2 and 3 with at least one flag set, the last register byte is followed by a repeated START and then a write of slv_reg_i[7:1] with bit 0 = 1.
- R6: In modes 2 and 3 with no register flag set, the sequence is START and then the slave byte with bit 0 = 1. No register byte and no repeated START are sent. Plain-read mode ignores the flags altogether.
- R7: A done with cmd_ack_i = 0 on any WRITE command is a NAK. It raises nak_evt_o for exactly one cycle, the next command is STOP, no hand-off pulse follows, and the block is idle once the STOP completes.
- R8: After the final acknowledged byte, exactly one of tx_go_o (mode 0) or rx_go_o (other modes) pulses for one cycle. busy_o is already 0 in that cycle, and with rx_go_o, rx_len_o equals the rx_len_i captured at go.
- R9: All configuration is captured when go is accepted. A go_i pulse, or changes on slv_reg_i, reg_addr_i, mode_i or rx_len_i, while busy has no effect on the transfer in flight.
- R10: While cmd_valid_o is 1 and cmd_done_i is 0, the command code and byte stay stable on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start strobe, taken only when idle |
| mode_i | input | 2 | Transfer mode (0 write-only, 1 read, 2 write-then-read, 3 read-then-read) |
| slv_reg_i | input | 32 | Slave address shifted left in [7:0], valid flag in bit 24 |
| reg_addr_i | input | 32 | Register bytes in [23:0], per-byte flags in [26:24] |
| rx_len_i | input | LEN_W | Receive count for the burst path |
| cmd_valid_o | output | 1 | A byte-engine command is pending |
| cmd_op_o | output | 2 | Command code |
| cmd_byte_o | output | 8 | Byte for WRITE commands |
| cmd_done_i | input | 1 | Engine finished the current command |
| cmd_ack_i | input | 1 | Acknowledge sampled with cmd_done_i |
| busy_o | output | 1 | Sequence in progress |
| tx_go_o | output | 1 | One-cycle hand-off to the transmit burst path |
| rx_go_o | output | 1 | One-cycle hand-off to the receive burst path |
| rx_len_o | output | LEN_W | Captured receive count |
| nak_evt_o | output | 1 | One-cycle NAK event |

## Verification
The bench works through sparse flag patterns, such as low and high flags set with the middle one clear. A picker that walks byte positions rather than set flags would then send a stale middle byte or repeat one. The direction bit is driven deliberately wrong on the input and checked in every mode and flag combination. An inverted rule would send a read address before the register bytes, or would skip the repeated START when flags are empty. NAKs are injected on the first address, on a middle register byte and on the read address: a design that ignores one would hand off to the burst path instead of stopping. A go pulse with fresh values in mid-transfer exposes any re-capture of the configuration.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  typedef enum logic [1:0] {
    OP_START  = 2'd0,
    OP_RSTART = 2'd1,
    OP_WRITE  = 2'd2,
    OP_STOP   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    MD_TX  = 2'd0,
    MD_RX  = 2'd1,
    MD_TRX = 2'd2,
    MD_RRX = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_WADR, S_REG, S_RST, S_RADR, S_STOP
  } st_e;

  localparam int SLV_VALID_BIT = 24;
  localparam int FLAG_LSB      = 24;

  // Direction bit of the first address byte.
  function automatic logic first_rw(input mode_e m, input logic any_reg);
    return !(m == MD_TX || (m == MD_TRX && any_reg));
  endfunction

  // Byte-engine command for each state.
  function automatic op_e op_of(input st_e s);
    case (s)
      S_START: return OP_START;
      S_RST:   return OP_RSTART;
      S_STOP:  return OP_STOP;
      default: return OP_WRITE;
    endcase
  endfunction

endpackage

// File: rtl/rdseq_regsel.sv
module rdseq_regsel #(
  parameter int NB = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [NB-1:0]   flags_i,
  input  logic [8*NB-1:0] bytes_i,
  input  logic            pop_i,
  output logic            any_o,
  output logic            last_o,
  output logic [7:0]      byte_o
);
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [NB-1:0] left_q;
  logic [7:0]    b_q [NB];
  logic [IW-1:0] cur;

  function automatic logic [IW-1:0] lowest(input logic [NB-1:0] m);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NB - 1; i >= 0; i--)
      if (m[i]) r = IW'(i);
    return r;
  endfunction

  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      b_q[gi] <= 8'h00;
      else if (load_i) b_q[gi] <= bytes_i[8*gi +: 8];
  end

  // Each acknowledged byte clears the lowest remaining flag.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      left_q <= '0;
    else if (load_i) left_q <= flags_i;
    else if (pop_i)  left_q <= left_q & (left_q - NB'(1));

  assign cur    = lowest(left_q);
  assign any_o  = |left_q;
  assign last_o = $onehot(left_q);
  assign byte_o = b_q[cur];
endmodule

// File: rtl/rdseq_fsm.sv
module rdseq_fsm
  import rdseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept_i,
  input  mode_e mode_i,
  input  logic  any_i,
  input  logic  last_i,
  input  logic  done_i,
  input  logic  ack_i,
  output st_e   st_o,
  output logic  pop_o,
  output logic  ev_nak_o,
  output logic  tx_go_o,
  output logic  rx_go_o,
  output logic  nak_o
);
  st_e st;

  assign st_o     = st;
  assign ev_nak_o = done_i && !ack_i && (st == S_WADR || st == S_REG || st == S_RADR);
  assign pop_o    = (st == S_REG) && done_i && ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tx_go_o <= 1'b0;
      rx_go_o <= 1'b0;
      nak_o   <= 1'b0;
    end else begin
      tx_go_o <= 1'b0;
      rx_go_o <= 1'b0;
      nak_o   <= 1'b0;
      if (ev_nak_o) begin
        st    <= S_STOP;
        nak_o <= 1'b1;
      end else begin
        case (st)
          S_IDLE:  if (accept_i) st <= S_START;
          S_START: if (done_i) st <= S_WADR;
          S_WADR:  if (done_i) begin
            if (mode_i != MD_RX && any_i) st <= S_REG;
            else begin
              st <= S_IDLE;
              if (mode_i == MD_TX) tx_go_o <= 1'b1;
              else                 rx_go_o <= 1'b1;
            end
          end
          S_REG:   if (done_i && last_i) begin
            if (mode_i == MD_TX) begin
              st      <= S_IDLE;
              tx_go_o <= 1'b1;
            end else st <= S_RST;
          end
          S_RST:   if (done_i) st <= S_RADR;
          S_RADR:  if (done_i) begin
            st      <= S_IDLE;
            rx_go_o <= 1'b1;
          end
          S_STOP:  if (done_i) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regread_seq.sv
module i2c_regread_seq
  import rdseq_pkg::*;
#(
  parameter int REG_BYTES = 3,
  parameter int LEN_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [1:0]       mode_i,
  input  logic [31:0]      slv_reg_i,
  input  logic [31:0]      reg_addr_i,
  input  logic [LEN_W-1:0] rx_len_i,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic [7:0]       cmd_byte_o,
  input  logic             cmd_done_i,
  input  logic             cmd_ack_i,
  output logic             busy_o,
  output logic             tx_go_o,
  output logic             rx_go_o,
  output logic [LEN_W-1:0] rx_len_o,
  output logic             nak_evt_o
);
  localparam int RB_W = 8 * REG_BYTES;

  st_e        st;
  mode_e      mode_q;
  logic [6:0] slv_q;
  logic       ev_accept, ev_nak, pop, any_reg, last_reg;
  logic [7:0] reg_byte;

  assign ev_accept = (st == S_IDLE) && go_i && slv_reg_i[SLV_VALID_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q   <= MD_TX;
      slv_q    <= '0;
      rx_len_o <= '0;
    end else if (ev_accept) begin
      mode_q   <= mode_e'(mode_i);
      slv_q    <= slv_reg_i[7:1];
      rx_len_o <= rx_len_i;
    end

  rdseq_regsel #(.NB(REG_BYTES)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (ev_accept),
    .flags_i (reg_addr_i[FLAG_LSB +: REG_BYTES]),
    .bytes_i (reg_addr_i[RB_W-1:0]),
    .pop_i   (pop),
    .any_o   (any_reg),
    .last_o  (last_reg),
    .byte_o  (reg_byte)
  );

  rdseq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (ev_accept),
    .mode_i   (mode_q),
    .any_i    (any_reg),
    .last_i   (last_reg),
    .done_i   (cmd_done_i),
    .ack_i    (cmd_ack_i),
    .st_o     (st),
    .pop_o    (pop),
    .ev_nak_o (ev_nak),
    .tx_go_o  (tx_go_o),
    .rx_go_o  (rx_go_o),
    .nak_o    (nak_evt_o)
  );

  assign busy_o      = (st != S_IDLE);
  assign cmd_valid_o = busy_o;
  assign cmd_op_o    = op_of(st);

  always_comb begin
    case (st)
      S_WADR:  cmd_byte_o = {slv_q, first_rw(mode_q, any_reg)};
      S_REG:   cmd_byte_o = reg_byte;
      S_RADR:  cmd_byte_o = {slv_q, 1'b1};
      default: cmd_byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rdseq_chk.sv
module rdseq_chk #(
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_i,
  input logic             slv_v,
  input logic             busy_o,
  input logic             cmd_valid_o,
  input logic [1:0]       cmd_op_o,
  input logic [7:0]       cmd_byte_o,
  input logic             cmd_done_i,
  input logic             cmd_ack_i,
  input logic             tx_go_o,
  input logic             rx_go_o,
  input logic             nak_evt_o,
  input logic [LEN_W-1:0] rx_len_o
);
  p_ignore_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && go_i && !slv_v) |=> !busy_o);

  p_first_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid_o) |-> cmd_op_o == 2'd0);

  p_read_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_go_o |-> ($past(cmd_byte_o[0]) && $past(cmd_op_o) == 2'd2 && $past(cmd_done_i && cmd_ack_i)));

  p_nak_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_op_o == 2'd2 && cmd_done_i && !cmd_ack_i) |=> (cmd_op_o == 2'd3 && nak_evt_o));

  p_handoff_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go_o || rx_go_o) |-> !busy_o);

  p_one_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_go_o, rx_go_o, nak_evt_o}));

  p_len_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(rx_len_o));

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_done_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_byte_o)));
endmodule

bind i2c_regread_seq rdseq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .go_i        (go_i),
  .slv_v       (slv_reg_i[24]),
  .busy_o      (busy_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_op_o    (cmd_op_o),
  .cmd_byte_o  (cmd_byte_o),
  .cmd_done_i  (cmd_done_i),
  .cmd_ack_i   (cmd_ack_i),
  .tx_go_o     (tx_go_o),
  .rx_go_o     (rx_go_o),
  .nak_evt_o   (nak_evt_o),
  .rx_len_o    (rx_len_o)
);

// File: tb/sim_i2c_regread_seq.sv
module sim_i2c_regread_seq;
  localparam int LEN_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             go_i = 1'b0;
  logic [1:0]       mode_i = '0;
  logic [31:0]      slv_reg_i = '0;
  logic [31:0]      reg_addr_i = '0;
  logic [LEN_W-1:0] rx_len_i = '0;
  logic             cmd_valid_o, busy_o, tx_go_o, rx_go_o, nak_evt_o;
  logic [1:0]       cmd_op_o;
  logic [7:0]       cmd_byte_o;
  logic             cmd_done_i = 1'b0;
  logic             cmd_ack_i = 1'b0;
  logic [LEN_W-1:0] rx_len_o;

  int checks = 0;
  int fails  = 0;
  bit tb_busy = 1'b0;

  // Expected command list of one transfer.
  int    e_op [16];
  int    e_by [16];
  string e_rq [16];
  int    n_exp;

  always #2 clk = ~clk;

  i2c_regread_seq #(.LEN_W(LEN_W)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor every clock: no command may be pending while no transfer is expected.
  always @(posedge clk) begin
    #1;
    if (rst_n) chk(tb_busy || !cmd_valid_o, "R2", int'(cmd_valid_o), 0);
  end

  task automatic add(input int op, input int by, input string rq);
    e_op[n_exp] = op;
    e_by[n_exp] = by;
    e_rq[n_exp] = rq;
    n_exp++;
  endtask

  // end_kind: 0 transmit hand-off, 1 receive hand-off, 2 NAK
  task automatic run(input int mode, input int slv7, input int flags,
                     input int b0, input int b1, input int b2,
                     input int nak_at, input int dly, input bit poke);
    int  end_kind, lsb, len;
    bit  regs;
    int  bv [3];
    bv[0] = b0; bv[1] = b1; bv[2] = b2;
    n_exp = 0;
    len   = (5 + mode * 7 + flags) % 64;
    add(0, 0, "R3");
    regs = (mode != 1) && (flags != 0);
    lsb  = (mode == 0 || (mode == 2 && flags != 0)) ? 0 : 1;
    add(2, slv7 * 2 + lsb, (mode != 0 && flags == 0) ? "R6" : "R3");
    if (regs)
      for (int i = 0; i < 3; i++)
        if (flags[i]) add(2, bv[i], "R4");
    if (mode == 0) end_kind = 0;
    else begin
      end_kind = 1;
      if (regs) begin
        add(1, 0, "R5");
        add(2, slv7 * 2 + 1, "R5");
      end
    end
    if (nak_at >= 0) begin
      n_exp = nak_at + 1;
      add(3, 0, "R7");
      end_kind = 2;
    end

    @(negedge clk);
    mode_i     = 2'(mode);
    slv_reg_i  = 32'h0100_0000 | 32'(slv7 * 2 + 1);   // bit 0 deliberately wrong
    reg_addr_i = 32'(flags << 24) | 32'(b2 << 16) | 32'(b1 << 8) | 32'(b0);
    rx_len_i   = LEN_W'(len);
    go_i       = 1'b1;
    tb_busy    = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    chk(busy_o == 1'b1, "R3", int'(busy_o), 1);

    for (int k = 0; k < n_exp; k++) begin
      chk(cmd_valid_o && int'(cmd_op_o) == e_op[k], e_rq[k], int'(cmd_op_o), e_op[k]);
      if (e_op[k] == 2) chk(int'(cmd_byte_o) == e_by[k], e_rq[k], int'(cmd_byte_o), e_by[k]);
      if (poke && k == 1) begin
        go_i       = 1'b1;
        mode_i     = 2'(3 - mode);
        slv_reg_i  = 32'h0100_00FE;
        reg_addr_i = 32'h07AB_CDEF;
        rx_len_i   = LEN_W'(len + 1);
        @(negedge clk);
        go_i = 1'b0;
        chk(int'(cmd_op_o) == e_op[k] && int'(cmd_byte_o) == (e_op[k] == 2 ? e_by[k] : 0),
            "R9", int'(cmd_byte_o), e_by[k]);
      end
      repeat (dly) begin
        @(negedge clk);
        chk(int'(cmd_op_o) == e_op[k], "R10", int'(cmd_op_o), e_op[k]);
      end
      cmd_done_i = 1'b1;
      cmd_ack_i  = (k == nak_at) ? 1'b0 : 1'b1;
      @(negedge clk);
      cmd_done_i = 1'b0;
      cmd_ack_i  = 1'b0;
      if (k == nak_at) chk(nak_evt_o == 1'b1, "R7", int'(nak_evt_o), 1);
    end

    chk(busy_o == 1'b0, "R8", int'(busy_o), 0);
    chk(tx_go_o == (end_kind == 0), "R8", int'(tx_go_o), int'(end_kind == 0));
    chk(rx_go_o == (end_kind == 1), "R8", int'(rx_go_o), int'(end_kind == 1));
    if (end_kind == 2) chk(nak_evt_o == 1'b0, "R7", int'(nak_evt_o), 0);
    if (end_kind == 1) chk(int'(rx_len_o) == len, "R8", int'(rx_len_o), len);
    tb_busy = 1'b0;
    @(negedge clk);
    chk(!tx_go_o && !rx_go_o && !nak_evt_o, "R8",
        int'({tx_go_o, rx_go_o, nak_evt_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !cmd_valid_o && !tx_go_o && !rx_go_o && !nak_evt_o, "R1",
        int'({busy_o, cmd_valid_o, tx_go_o, rx_go_o, nak_evt_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !cmd_valid_o, "R1", int'(busy_o), 0);

    // R2: slave-address valid flag clear
    slv_reg_i  = 32'h0000_00A0;
    reg_addr_i = 32'h0711_2233;
    mode_i     = 2'd2;
    go_i       = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !cmd_valid_o, "R2", int'(busy_o), 0);

    run(2, 7'h50, 3'b001, 8'h11, 8'h22, 8'h33, -1, 0, 1'b0);
    run(2, 7'h50, 3'b111, 8'h11, 8'h22, 8'h33, -1, 1, 1'b0);
    run(2, 7'h2C, 3'b101, 8'hA5, 8'h5A, 8'hC3, -1, 2, 1'b0);   // R4 sparse flags
    run(0, 7'h13, 3'b010, 8'h01, 8'h02, 8'h03, -1, 0, 1'b0);
    run(0, 7'h13, 3'b000, 8'h01, 8'h02, 8'h03, -1, 1, 1'b0);
    run(1, 7'h7F, 3'b111, 8'h44, 8'h55, 8'h66, -1, 0, 1'b0);
    run(3, 7'h21, 3'b011, 8'h9A, 8'hBC, 8'hDE, -1, 1, 1'b0);
    run(2, 7'h35, 3'b000, 8'h9A, 8'hBC, 8'hDE, -1, 0, 1'b0);   // R6
    run(3, 7'h35, 3'b000, 8'h9A, 8'hBC, 8'hDE, -1, 2, 1'b0);   // R6
    run(2, 7'h50, 3'b111, 8'h11, 8'h22, 8'h33, 1, 0, 1'b0);    // R7 NAK on slave byte
    run(2, 7'h50, 3'b111, 8'h11, 8'h22, 8'h33, 3, 1, 1'b0);    // R7 NAK on middle byte
    run(3, 7'h50, 3'b100, 8'h11, 8'h22, 8'h33, 4, 0, 1'b0);    // R7 NAK on read address
    run(2, 7'h66, 3'b110, 8'h71, 8'h72, 8'h73, -1, 1, 1'b1);   // R9 go while busy
    run(0, 7'h66, 3'b111, 8'h71, 8'h72, 8'h73, -1, 0, 1'b1);   // R9

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule